// File: doc/BRIEF.md
# Masked Block Write Engine

This block is the write datapath of a video frame store that fills screen areas quickly. In one clock cycle it copies a stored color word into a group of eight neighbouring columns of one row. Three conditions decide whether a bit is written. A per-column mask comes in on the data bus. A write mask limits which bit positions change. Two byte strobes enable the lower and upper halves of each word.

The color word and the write mask live in two registers. Each is loaded by its own command from the data bus, and the byte strobes act on those loads as well. A block write comes in two forms. The masked form applies the write-mask register. The plain form enables every bit position, whatever the mask register holds. The block writes a behavioural storage array and reports, one cycle later, the full vector of per-column, per-bit write enables it used. A combinational read port gives access to any array word.

Top module: `bwe_top`

## Requirements
- R1: While reset is asserted and directly after it, `wen` is all zeros, the color register is 0, the write-mask register is all ones, and every array word reads as 0.
- R2: When `cmd_valid` is high, `cmd_op` selects the operation: 0 loads the color register, 1 loads the write-mask register, 2 is a masked block write, and 3 is a plain block write.
- R3: A color or write-mask load copies `cmd_dq[7:0]` only when `strb_lo` is high, and copies `cmd_dq[15:8]` only when `strb_hi` is high. A byte whose strobe is low keeps its old value. A loaded value holds until the next load of the same register.
- R4: A block write targets columns `{cmd_col[5:3], k}` for k = 0..7 of row `cmd_row`. `cmd_col[2:0]` has no effect.
- R5: During a block write, `cmd_dq[k]` enables the lower byte of column k, and `cmd_dq[8+k]` enables the upper byte of column k. An enabled bit takes the value of the matching color-register bit.
- R6: `strb_lo` gates bits 0..7 and `strb_hi` gates bits 8..15 of every column in a block write. With both strobes low, nothing is written.
- R7: A masked block write changes bit b only where write-mask bit b is 1.
- R8: A plain block write ignores the write-mask register and enables all 16 bits wherever the column mask and strobes allow.
- R9: On the clock edge that accepts a block write, `wen` takes the enable vector, with bit `k*16+b` meaning bit b of column k. On the same edge, `wen_row` and `wen_blk` take the row and block. After an edge with no block write, `wen` is 0.
- R10: `rd_data` shows the array word at `{rd_row, rd_col}` combinationally. A write is visible right after its edge. Bits and columns that were not enabled keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Operation code (R2) |
| cmd_row | input | ROW_W (2) | Row address |
| cmd_col | input | COL_W (6) | Column address; low 3 bits ignored for block writes |
| cmd_dq | input | DATA_W (16) | Load value or column mask |
| strb_lo | input | 1 | Lower byte strobe |
| strb_hi | input | 1 | Upper byte strobe |
| rd_row | input | ROW_W (2) | Read row |
| rd_col | input | COL_W (6) | Read column |
| rd_data | output | DATA_W (16) | Array word at the read address |
| wen | output | 8*DATA_W (128) | Registered per-column, per-bit write enables |
| wen_row | output | ROW_W (2) | Row of the last block write |
| wen_blk | output | COL_W-3 (3) | Block of the last block write |

## Verification
Every result is due on the first rising edge after a command is presented. At that edge `wen`, `wen_row` and `wen_blk` register, the array takes the write, and the color or mask register loads. The bench drives each command at a falling edge and withdraws it at the next falling edge. It checks `wen` at that falling edge, before another edge can clear it. It then reads the block and a neighbouring word through the combinational read port while no command is active. A load is first used by the next command, and the bench's reference registers change at the same point.

// File: rtl/bwe_pkg.sv
package bwe_pkg;
  localparam int LOW_W = 3;
  localparam int BLK_COLS = 1 << LOW_W;

  typedef enum logic [1:0] {
    OP_LOAD_COLOR = 2'd0,
    OP_LOAD_MASK  = 2'd1,
    OP_BW_MASKED  = 2'd2,
    OP_BW_PLAIN   = 2'd3
  } bwe_op_e;
endpackage

// File: rtl/bwe_regs.sv
module bwe_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_color,
  input  logic              ld_mask,
  input  logic [DATA_W-1:0] dq,
  input  logic              strb_lo,
  input  logic              strb_hi,
  output logic [DATA_W-1:0] color_q,
  output logic [DATA_W-1:0] wmask_q
);
  localparam int BYTE_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] byte_merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic              lo,
    input logic              hi
  );
    logic [DATA_W-1:0] sel;
    sel = {{BYTE_W{hi}}, {BYTE_W{lo}}};
    return (new_v & sel) | (old_v & ~sel);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      color_q <= '0;
      wmask_q <= '1;
    end else begin
      if (ld_color) color_q <= byte_merge(color_q, dq, strb_lo, strb_hi);
      if (ld_mask)  wmask_q <= byte_merge(wmask_q, dq, strb_lo, strb_hi);
    end
  end
endmodule

// File: rtl/bwe_enable_gen.sv
module bwe_enable_gen
  import bwe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       fire,
  input  logic                       plain,
  input  logic [DATA_W-1:0]          dq,
  input  logic                       strb_lo,
  input  logic                       strb_hi,
  input  logic [DATA_W-1:0]          wmask,
  output logic [BLK_COLS*DATA_W-1:0] en_vec
);
  localparam int BYTE_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] col_enables(
    input logic              col_lo,
    input logic              col_hi,
    input logic              lo,
    input logic              hi,
    input logic              all_bits,
    input logic [DATA_W-1:0] mask
  );
    logic [DATA_W-1:0] bytes;
    bytes = {{BYTE_W{col_hi & hi}}, {BYTE_W{col_lo & lo}}};
    return all_bits ? bytes : (bytes & mask);
  endfunction

  for (genvar k = 0; k < BLK_COLS; k++) begin : g_col
    logic [DATA_W-1:0] col_en;
    assign col_en = col_enables(dq[k], dq[BYTE_W+k], strb_lo, strb_hi, plain, wmask);
    assign en_vec[k*DATA_W +: DATA_W] = fire ? col_en : '0;
  end
endmodule

// File: rtl/bwe_array.sv
module bwe_array
  import bwe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [BLK_COLS*DATA_W-1:0] we_vec,
  input  logic [ROW_W-1:0]           wr_row,
  input  logic [COL_W-LOW_W-1:0]     wr_blk,
  input  logic [DATA_W-1:0]          color,
  input  logic [ROW_W-1:0]           rd_row,
  input  logic [COL_W-1:0]           rd_col,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int k = 0; k < BLK_COLS; k++) begin
        for (int b = 0; b < DATA_W; b++) begin
          if (we_vec[k*DATA_W+b]) mem[{wr_row, wr_blk, LOW_W'(k)}][b] <= color[b];
        end
      end
    end
  end

  assign rd_data = mem[{rd_row, rd_col}];
endmodule

// File: rtl/bwe_top.sv
module bwe_top
  import bwe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic [ROW_W-1:0]           cmd_row,
  input  logic [COL_W-1:0]           cmd_col,
  input  logic [DATA_W-1:0]          cmd_dq,
  input  logic                       strb_lo,
  input  logic                       strb_hi,
  input  logic [ROW_W-1:0]           rd_row,
  input  logic [COL_W-1:0]           rd_col,
  output logic [DATA_W-1:0]          rd_data,
  output logic [BLK_COLS*DATA_W-1:0] wen,
  output logic [ROW_W-1:0]           wen_row,
  output logic [COL_W-LOW_W-1:0]     wen_blk
);
  localparam int BLK_W = COL_W - LOW_W;

  bwe_op_e op;
  logic ld_color, ld_mask, bw_fire, bw_plain;
  logic [BLK_W-1:0] cmd_blk;
  logic [LOW_W-1:0] unused_col_low;
  logic [DATA_W-1:0] color_q, wmask_q;
  logic [BLK_COLS*DATA_W-1:0] en_vec;

  assign op             = bwe_op_e'(cmd_op);
  assign ld_color       = cmd_valid && (op == OP_LOAD_COLOR);
  assign ld_mask        = cmd_valid && (op == OP_LOAD_MASK);
  assign bw_fire        = cmd_valid && ((op == OP_BW_MASKED) || (op == OP_BW_PLAIN));
  assign bw_plain       = (op == OP_BW_PLAIN);
  assign cmd_blk        = cmd_col[COL_W-1:LOW_W];
  assign unused_col_low = cmd_col[LOW_W-1:0];

  bwe_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_color(ld_color), .ld_mask(ld_mask),
    .dq(cmd_dq), .strb_lo(strb_lo), .strb_hi(strb_hi),
    .color_q(color_q), .wmask_q(wmask_q)
  );

  bwe_enable_gen #(.DATA_W(DATA_W)) u_gen (
    .fire(bw_fire), .plain(bw_plain), .dq(cmd_dq),
    .strb_lo(strb_lo), .strb_hi(strb_hi), .wmask(wmask_q), .en_vec(en_vec)
  );

  bwe_array #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we_vec(en_vec), .wr_row(cmd_row), .wr_blk(cmd_blk),
    .color(color_q), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wen     <= '0;
      wen_row <= '0;
      wen_blk <= '0;
    end else begin
      wen <= en_vec;
      if (bw_fire) begin
        wen_row <= cmd_row;
        wen_blk <= cmd_blk;
      end
    end
  end
endmodule

// File: rtl/bwe_chk.sv
module bwe_chk
  import bwe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic [1:0]                 cmd_op,
  input logic [DATA_W-1:0]          cmd_dq,
  input logic                       strb_lo,
  input logic                       strb_hi,
  input logic [BLK_COLS*DATA_W-1:0] wen,
  input logic [DATA_W-1:0]          color_q,
  input logic [DATA_W-1:0]          wmask_q
);
  localparam int BYTE_W = DATA_W / 2;

  logic wen_lo_any, wen_hi_any;
  always_comb begin
    wen_lo_any = 1'b0;
    wen_hi_any = 1'b0;
    for (int k = 0; k < BLK_COLS; k++) begin
      wen_lo_any = wen_lo_any | (|wen[k*DATA_W +: BYTE_W]);
      wen_hi_any = wen_hi_any | (|wen[k*DATA_W+BYTE_W +: BYTE_W]);
    end
  end

  // R9
  wen_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wen) |-> $past(cmd_valid && cmd_op[1]));

  // R2
  load_no_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_op[1]) |=> (wen == '0));

  // R6
  lo_strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1] && !strb_lo) |=> !wen_lo_any);

  // R6
  hi_strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1] && !strb_hi) |=> !wen_hi_any);

  // R8
  plain_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3 && strb_lo && strb_hi && (&cmd_dq)) |=> (&wen));

  // R7
  mask_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |=> ((wen & ~{BLK_COLS{$past(wmask_q)}}) == '0));

  // R3
  color_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && strb_lo && strb_hi) |=> (color_q == $past(cmd_dq)));

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && !strb_lo && !strb_hi) |=> $stable(wmask_q));
endmodule

bind bwe_top bwe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dq(cmd_dq),
  .strb_lo(strb_lo), .strb_hi(strb_hi), .wen(wen), .color_q(color_q), .wmask_q(wmask_q)
);

// File: tb/bwe_top_tb.sv
`timescale 1ns/1ps
module bwe_top_tb;
  localparam int DW = 16;
  localparam int RW = 2;
  localparam int CW = 6;
  localparam int WORDS = 1 << (RW + CW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [RW-1:0] cmd_row = '0;
  logic [CW-1:0] cmd_col = '0;
  logic [DW-1:0] cmd_dq = '0;
  logic strb_lo = 1'b0, strb_hi = 1'b0;
  logic [RW-1:0] rd_row = '0;
  logic [CW-1:0] rd_col = '0;
  logic [DW-1:0] rd_data;
  logic [8*DW-1:0] wen;
  logic [RW-1:0] wen_row;
  logic [CW-4:0] wen_blk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [DW-1:0] m_color, m_mask;
  logic [DW-1:0] ref_mem [WORDS];
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  bwe_top u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_dq(cmd_dq), .strb_lo(strb_lo), .strb_hi(strb_hi),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data), .wen(wen),
    .wen_row(wen_row), .wen_blk(wen_blk)
  );

  task automatic check(input string tag, input logic [8*DW-1:0] act, input logic [8*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  task automatic read_word(input int idx, input string tag);
    rd_row = RW'(idx / (1 << CW));
    rd_col = CW'(idx % (1 << CW));
    #1;
    check(tag, {112'd0, rd_data}, {112'd0, ref_mem[idx]});
  endtask

  // Drive one command, model it, and check its results (R2..R10).
  task automatic issue(input logic [1:0] op, input int row, input int col,
                       input logic [DW-1:0] dq, input logic lo, input logic hi);
    logic [8*DW-1:0] exp_wen;
    int blk, base;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_row = RW'(row); cmd_col = CW'(col);
    cmd_dq = dq; strb_lo = lo; strb_hi = hi;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    blk = col / 8;
    base = row * 64 + blk * 8;
    exp_wen = '0;
    if (op >= 2'd2) begin
      for (int i = 0; i < 8 * DW; i++) begin
        int k, b;
        logic colbit, strobe, maskbit;
        k = i / DW;
        b = i % DW;
        colbit = (b < 8) ? dq[k] : dq[8 + k];
        strobe = (b < 8) ? lo : hi;
        maskbit = (op == 2'd3) ? 1'b1 : m_mask[b];
        exp_wen[i] = colbit & strobe & maskbit;
        if (exp_wen[i]) ref_mem[base + k][b] = m_color[b];
      end
      check("R9 wen vector (R5 R6 R7 R8)", wen, exp_wen);
      check("R9 wen_row/wen_blk (R4)", {123'd0, wen_row, wen_blk}, {123'd0, RW'(row), 3'(blk)});
    end else begin
      check("R2 load leaves wen zero", wen, '0);
      for (int b = 0; b < DW; b++) begin
        if ((b < 8) ? lo : hi) begin
          if (op == 2'd0) m_color[b] = dq[b];
          else m_mask[b] = dq[b];
        end
      end
    end
    if (op >= 2'd2) begin
      for (int k = 0; k < 8; k++) read_word(base + k, "R10 block word (R4 R5)");
      read_word((base + 8) % WORDS, "R10 neighbour untouched (R4)");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_color = '0;
    m_mask = '1;
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset wen", wen, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wen after reset", wen, '0);
    read_word(0, "R1 array cleared");
    read_word(WORDS - 1, "R1 array cleared");
    // R1: reset mask is all ones, reset color is zero; a masked write of color 0 over zeros
    issue(2'd2, 1, 9, 16'hFFFF, 1'b1, 1'b1);

    // R3: color load byte by byte
    issue(2'd0, 0, 0, 16'hA5C3, 1'b1, 1'b1);
    issue(2'd0, 0, 0, 16'h1177, 1'b0, 1'b0);
    issue(2'd0, 0, 0, 16'h3C00, 1'b0, 1'b1);
    // R4 R8: plain fill of every block with varying ignored low column bits
    for (int r = 0; r < 4; r++)
      for (int bk = 0; bk < 8; bk++)
        issue(2'd3, r, bk * 8 + ((r + bk) % 8), 16'hFFFF, 1'b1, 1'b1);

    // R3 R7: masked write with a partly loaded mask
    issue(2'd1, 0, 0, 16'h0F0F, 1'b1, 1'b1);
    issue(2'd1, 0, 0, 16'hFFFF, 1'b0, 1'b1);
    issue(2'd0, 0, 0, 16'h5AA5, 1'b1, 1'b1);
    issue(2'd2, 2, 21, 16'hFFFF, 1'b1, 1'b1);
    // R8: plain write ignores the loaded mask
    issue(2'd3, 2, 40, 16'h81C3, 1'b1, 1'b1);

    // R5 R6: sweep strobe combinations, modes and column-mask patterns
    for (int s = 0; s < 4; s++)
      for (int m = 2; m < 4; m++)
        for (int p = 0; p < 4; p++)
          issue(2'(m), p, p * 17 + s, 16'h1 << (p * 4 + s) | 16'h0180 >> p, s[0], s[1]);

    // R2..R10: pseudo-random mixed traffic
    for (int n = 0; n < 300; n++) begin
      seed = next_rand(seed);
      issue(seed[1:0], int'(seed[3:2]), int'(seed[9:4]), seed[31:16], seed[10] | seed[12], seed[11] | seed[13]);
    end

    @(negedge clk);
    check("R9 wen zero in idle cycle", wen, '0);
    for (int i = 0; i < WORDS; i++) read_word(i, "R10 final array scan");

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule